// File: doc/BRIEF.md
# Cell-Based Transmit FIFO with Start Threshold

This block sits between a memory-fetch engine and an Ethernet MAC transmitter. The fetch side pushes packet data as 64-bit words, eight bytes at a time, and marks the last word of each packet with an end-of-packet flag and a count of its valid bytes. Inside, the storage is split into 24 cells of 64 bytes. The wire side pulls one byte per cycle once the block has given permission to transmit.

Permission to start a packet is granted when the number of complete cells held reaches a programmable threshold, or when the whole packet is already held, whichever comes first. A low threshold gives cut-through behaviour with little latency. The largest threshold of 24 cells gives store-and-forward for packets of up to 1536 bytes. If the wire side asks for a byte from a cell that is not yet complete, the block reports an underrun, throws away the rest of that packet up to its end marker, and then waits for the next packet.

Top module: `txcell_fifo`

## Requirements
- R1: The block holds at most 24 complete cells. `wr_ready` is low while 24 complete cells are held, and a word presented with `wr_valid` high while `wr_ready` is low is not stored and does not change the byte stream.
- R2: In idle, `tx_active` rises one cycle after the write that makes the number of complete cells equal to the effective threshold.
- R3: In idle, `tx_active` rises one cycle after the end-of-packet word of a packet is written, even when fewer cells than the threshold are complete.
- R4: The effective threshold is `cfg_thresh` when it is 1 to 24. A value of 0 counts as 1, and any value above 24 counts as 24.
- R5: A cell becomes complete when its eighth word is written or when a word with `wr_eop` high is written into it. `wr_last_bytes` gives the valid bytes of the end-of-packet word (1 to 7), and 0 means all 8.
- R6: While `tx_active` is high, `rd_en` in a cycle with a complete head cell produces `rd_valid` and the byte on `rd_data` in the next cycle. Bytes leave in write order, and within a word bits 7:0 come first. `rd_last` marks the final byte of a packet, and `tx_active` is low in the cycle after that byte appears.
- R7: A packet of no more than threshold × 64 bytes, written at full rate and read every cycle from the start, never underruns.
- R8: `rd_en` while `tx_active` is high and no complete cell is held gives a one-cycle `underrun` pulse in the next cycle, with no `rd_valid`, and `tx_active` low from that cycle on.
- R9: After an underrun, every remaining byte of the packet up to and including its end-of-packet word is discarded. The next packet is then sent complete and from its first byte.
- R10: After reset, `wr_ready` is high and `tx_active`, `rd_valid`, `rd_last` and `underrun` are low.
- R11: `rd_en` while `tx_active` is low produces neither `rd_valid` nor `underrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_thresh | input | 5 | Start threshold in complete cells |
| wr_valid | input | 1 | Write word present |
| wr_ready | output | 1 | A word can be stored this cycle |
| wr_data | input | 64 | Write word, byte 0 in bits 7:0 |
| wr_eop | input | 1 | Word is the last one of its packet |
| wr_last_bytes | input | 3 | Valid bytes in the end-of-packet word, 0 means 8 |
| rd_en | input | 1 | Wire side requests one byte |
| tx_active | output | 1 | A packet is being sent |
| rd_valid | output | 1 | `rd_data` holds a packet byte |
| rd_data | output | 8 | Packet byte |
| rd_last | output | 1 | Byte is the final one of its packet |
| underrun | output | 1 | One-cycle pulse when a requested byte was missing |

## Verification
The bench aims at the start decision: when the threshold boundary and the packet end fall on the same word, a design that counted cells one word late, or ignored the clamp for 0 and values above 24, would raise `tx_active` a cycle late or wait for data that never comes. It sends packets of 1 byte, exactly one cell, one byte past a cell, and exactly full storage, so that a wrong partial-cell length would repeat or lose bytes at a cell seam. Underrun is forced with a slow writer, and a design that failed to discard up to the end marker would send leftover bytes in front of the next packet. A full FIFO with junk words held on the write port shows whether writes leak through while `wr_ready` is low.

// File: rtl/txfifo_pkg.sv
// Shared types for the cell-based transmit FIFO.
// Assumes: nothing beyond IEEE 1800-2017.
package txfifo_pkg;

    // Wire-side sequencer state
    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,   // waiting for a start condition
        RD_SEND = 2'd1,   // streaming bytes of the head packet
        RD_DROP = 2'd2    // discarding the rest of an underrun packet
    } rd_state_t;

endpackage

// File: rtl/txf_thresh.sv
// Start decision for the cell FIFO.
// Clamps the programmed threshold into 1..NUM_CELLS and asserts start_ok when
// enough complete cells are held or when at least one whole packet is held.
// Assumes: count_full and pkts_held are registered counts from the top level.
module txf_thresh #(
    parameter int NUM_CELLS = 24,
    parameter int CNT_W     = $clog2(NUM_CELLS + 1)
) (
    input  logic [CNT_W-1:0] cfg_thresh,
    input  logic [CNT_W-1:0] count_full,
    input  logic [CNT_W-1:0] pkts_held,
    output logic [CNT_W-1:0] thr_eff,
    output logic             start_ok
);

    // clamp the programmed value into the legal range
    always_comb begin
        if (cfg_thresh == '0)
            thr_eff = CNT_W'(1);
        else if (cfg_thresh > CNT_W'(NUM_CELLS))
            thr_eff = CNT_W'(NUM_CELLS);
        else
            thr_eff = cfg_thresh;
    end

    // start on cell count or on a fully buffered packet
    always_comb begin
        start_ok = (count_full >= thr_eff) || (pkts_held != '0);
    end

    // R4: the effective threshold always lies in 1..NUM_CELLS
    always_comb begin
        if (!$isunknown(cfg_thresh)) begin
            a_thr_range_r4: assert (thr_eff != '0 && thr_eff <= CNT_W'(NUM_CELLS));
        end
    end

endmodule

// File: rtl/txf_wr_ctrl.sv
// Write-side cell allocator.
// Accepts one word per cycle while space_ok is high, tracks the open cell and
// the word offset inside it, and closes the cell after its last word or on an
// end-of-packet word, reporting the cell length in bytes.
// Assumes: WORDS_PER_CELL is a power of two; space_ok is high when the open
// cell is not still held by the read side.
module txf_wr_ctrl #(
    parameter int NUM_CELLS      = 24,
    parameter int WORDS_PER_CELL = 8,
    parameter int WORD_BYTES     = 8,
    parameter int CELL_IDX_W     = $clog2(NUM_CELLS),
    parameter int WOFF_W         = $clog2(WORDS_PER_CELL),
    parameter int LANE_W         = $clog2(WORD_BYTES),
    parameter int LEN_W          = WOFF_W + LANE_W + 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_valid,
    input  logic                         wr_eop,
    input  logic [LANE_W-1:0]            wr_last_bytes,
    input  logic                         space_ok,
    output logic                         wr_fire,
    output logic [CELL_IDX_W+WOFF_W-1:0] wr_addr,
    output logic                         close_cell,
    output logic [CELL_IDX_W-1:0]        close_idx,
    output logic [LEN_W-1:0]             close_len,
    output logic                         close_eop
);

    logic [CELL_IDX_W-1:0] wc;
    logic [WOFF_W-1:0]     woff;
    logic [LEN_W-1:0]      nbytes;

    // handshake and cell-close decode
    always_comb begin
        wr_fire    = wr_valid && space_ok;
        close_cell = wr_fire && (wr_eop || (woff == WOFF_W'(WORDS_PER_CELL - 1)));
        close_idx  = wc;
        close_eop  = wr_eop;
        wr_addr    = {wc, woff};
    end

    // byte length of the cell being closed
    always_comb begin
        if (wr_eop && wr_last_bytes != '0)
            nbytes = LEN_W'(wr_last_bytes);
        else
            nbytes = LEN_W'(WORD_BYTES);
        close_len = LEN_W'({woff, {LANE_W{1'b0}}}) + nbytes;
    end

    // advance open cell and word offset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wc   <= '0;
            woff <= '0;
        end else if (wr_fire) begin
            if (close_cell) begin
                woff <= '0;
                wc   <= (wc == CELL_IDX_W'(NUM_CELLS - 1)) ? '0 : wc + 1'b1;
            end else begin
                woff <= woff + 1'b1;
            end
        end
    end

    // R5: a packet end always leaves the next word at a cell start
    p_cell_closed_on_eop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && wr_eop) |=> (wr_addr[WOFF_W-1:0] == '0));

endmodule

// File: rtl/txf_rd_ctrl.sv
// Wire-side sequencer.
// Waits for start_ok, then hands out one byte per rd_en from the head cell,
// popping cells as they empty. A request with no complete cell raises a
// one-cycle underrun and switches to discarding cells up to the packet end.
// Assumes: head_len/head_eop describe the cell at head_idx and are valid
// whenever head_ready is high.
module txf_rd_ctrl
    import txfifo_pkg::*;
#(
    parameter int NUM_CELLS  = 24,
    parameter int CELL_BYTES = 64,
    parameter int CELL_IDX_W = $clog2(NUM_CELLS),
    parameter int BOFF_W     = $clog2(CELL_BYTES),
    parameter int LEN_W      = BOFF_W + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_en,
    input  logic                  start_ok,
    input  logic                  head_ready,
    input  logic [LEN_W-1:0]      head_len,
    input  logic                  head_eop,
    output logic [CELL_IDX_W-1:0] head_idx,
    output logic [BOFF_W-1:0]     byte_off,
    output logic                  byte_fire,
    output logic                  pop_cell,
    output logic                  pop_eop,
    output logic                  tx_active,
    output logic                  rd_valid,
    output logic                  rd_last,
    output logic                  underrun
);

    rd_state_t             state;
    logic [CELL_IDX_W-1:0] rc;
    logic [BOFF_W-1:0]     ro;
    logic                  cell_end;
    logic                  pop_send;
    logic                  pop_drop;
    logic                  starve;

    // per-cycle decode of the read request
    always_comb begin
        byte_fire = (state == RD_SEND) && rd_en && head_ready;
        cell_end  = (LEN_W'(ro) + LEN_W'(1)) == head_len;
        pop_send  = byte_fire && cell_end;
        pop_drop  = (state == RD_DROP) && head_ready;
        pop_cell  = pop_send || pop_drop;
        pop_eop   = pop_cell && head_eop;
        starve    = (state == RD_SEND) && rd_en && !head_ready;
        head_idx  = rc;
        byte_off  = ro;
        tx_active = (state == RD_SEND);
    end

    // state, pointers and registered wire-side outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= RD_IDLE;
            rc       <= '0;
            ro       <= '0;
            rd_valid <= 1'b0;
            rd_last  <= 1'b0;
            underrun <= 1'b0;
        end else begin
            rd_valid <= byte_fire;
            rd_last  <= pop_send && head_eop;
            underrun <= starve;
            if (pop_cell) begin
                ro <= '0;
                rc <= (rc == CELL_IDX_W'(NUM_CELLS - 1)) ? '0 : rc + 1'b1;
            end else if (byte_fire) begin
                ro <= ro + 1'b1;
            end
            case (state)
                RD_IDLE: if (start_ok) state <= RD_SEND;
                RD_SEND: begin
                    if (starve)                    state <= RD_DROP;
                    else if (pop_send && head_eop) state <= RD_IDLE;
                end
                RD_DROP: if (pop_eop) state <= RD_IDLE;
                default: state <= RD_IDLE;
            endcase
        end
    end

    // R6: a byte only appears in answer to a request
    p_valid_after_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_en));

    // R11: no byte unless transmission was active one cycle earlier
    p_idle_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tx_active) |-> !rd_valid);

    // R8: underrun is a single-cycle pulse
    p_underrun_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> !underrun);

    // R8: underrun carries no data and ends the send phase
    p_underrun_no_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> (!rd_valid && !tx_active));

    // R9: a discarded packet never resumes sending without going idle first
    p_drop_to_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RD_DROP) |=> (state != RD_SEND));

endmodule

// File: rtl/txcell_fifo.sv
// Cell-based transmit FIFO with a cut-through start threshold.
// Stores NUM_CELLS cells of CELL_BYTES bytes, written a word at a time and
// read a byte at a time. Keeps per-cell length and end-of-packet flags, the
// count of complete cells and the count of whole packets held.
// Assumes: CELL_BYTES/WORD_BYTES is a power of two; the wire side only
// asserts rd_en for the packet it is sending.
module txcell_fifo
    import txfifo_pkg::*;
#(
    parameter int NUM_CELLS  = 24,
    parameter int CELL_BYTES = 64,
    parameter int WORD_BYTES = 8,
    parameter int THR_W      = $clog2(NUM_CELLS + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [THR_W-1:0]        cfg_thresh,
    input  logic                    wr_valid,
    output logic                    wr_ready,
    input  logic [8*WORD_BYTES-1:0] wr_data,
    input  logic                    wr_eop,
    input  logic [$clog2(WORD_BYTES)-1:0] wr_last_bytes,
    input  logic                    rd_en,
    output logic                    tx_active,
    output logic                    rd_valid,
    output logic [7:0]              rd_data,
    output logic                    rd_last,
    output logic                    underrun
);

    localparam int WORD_W         = 8 * WORD_BYTES;
    localparam int WORDS_PER_CELL = CELL_BYTES / WORD_BYTES;
    localparam int DEPTH          = NUM_CELLS * WORDS_PER_CELL;
    localparam int CELL_IDX_W     = $clog2(NUM_CELLS);
    localparam int WOFF_W         = $clog2(WORDS_PER_CELL);
    localparam int LANE_W         = $clog2(WORD_BYTES);
    localparam int BOFF_W         = $clog2(CELL_BYTES);
    localparam int LEN_W          = BOFF_W + 1;
    localparam int ADDR_W         = CELL_IDX_W + WOFF_W;
    localparam int CNT_W          = THR_W;

    logic [WORD_W-1:0]     mem      [DEPTH];
    logic [LEN_W-1:0]      cell_len [NUM_CELLS];
    logic                  cell_eop [NUM_CELLS];

    logic [CNT_W-1:0]      count_full;
    logic [CNT_W-1:0]      pkts_held;
    logic [CNT_W-1:0]      thr_eff;
    logic                  start_ok;
    logic                  space_ok;

    logic                  wr_fire;
    logic [ADDR_W-1:0]     wr_addr;
    logic                  close_cell;
    logic [CELL_IDX_W-1:0] close_idx;
    logic [LEN_W-1:0]      close_len;
    logic                  close_eop;

    logic [CELL_IDX_W-1:0] head_idx;
    logic [BOFF_W-1:0]     byte_off;
    logic                  byte_fire;
    logic                  pop_cell;
    logic                  pop_eop;
    logic                  head_ready;
    logic [LEN_W-1:0]      head_len;
    logic                  head_eop;
    logic [ADDR_W-1:0]     rd_addr;
    logic [LANE_W-1:0]     rd_lane;

    // space and head-cell view
    always_comb begin
        space_ok   = count_full < CNT_W'(NUM_CELLS);
        wr_ready   = space_ok;
        head_ready = count_full != '0;
        head_len   = cell_len[head_idx];
        head_eop   = cell_eop[head_idx];
        rd_addr    = {head_idx, byte_off[BOFF_W-1:LANE_W]};
        rd_lane    = byte_off[LANE_W-1:0];
    end

    txf_thresh #(
        .NUM_CELLS (NUM_CELLS),
        .CNT_W     (CNT_W)
    ) u_thresh (
        .cfg_thresh (cfg_thresh),
        .count_full (count_full),
        .pkts_held  (pkts_held),
        .thr_eff    (thr_eff),
        .start_ok   (start_ok)
    );

    txf_wr_ctrl #(
        .NUM_CELLS      (NUM_CELLS),
        .WORDS_PER_CELL (WORDS_PER_CELL),
        .WORD_BYTES     (WORD_BYTES),
        .CELL_IDX_W     (CELL_IDX_W),
        .WOFF_W         (WOFF_W),
        .LANE_W         (LANE_W),
        .LEN_W          (LEN_W)
    ) u_wr (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_valid      (wr_valid),
        .wr_eop        (wr_eop),
        .wr_last_bytes (wr_last_bytes),
        .space_ok      (space_ok),
        .wr_fire       (wr_fire),
        .wr_addr       (wr_addr),
        .close_cell    (close_cell),
        .close_idx     (close_idx),
        .close_len     (close_len),
        .close_eop     (close_eop)
    );

    txf_rd_ctrl #(
        .NUM_CELLS  (NUM_CELLS),
        .CELL_BYTES (CELL_BYTES),
        .CELL_IDX_W (CELL_IDX_W),
        .BOFF_W     (BOFF_W),
        .LEN_W      (LEN_W)
    ) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (rd_en),
        .start_ok   (start_ok),
        .head_ready (head_ready),
        .head_len   (head_len),
        .head_eop   (head_eop),
        .head_idx   (head_idx),
        .byte_off   (byte_off),
        .byte_fire  (byte_fire),
        .pop_cell   (pop_cell),
        .pop_eop    (pop_eop),
        .tx_active  (tx_active),
        .rd_valid   (rd_valid),
        .rd_last    (rd_last),
        .underrun   (underrun)
    );

    // data storage write port
    always_ff @(posedge clk) begin
        if (wr_fire)
            mem[wr_addr] <= wr_data;
    end

    // per-cell metadata written when a cell closes
    always_ff @(posedge clk) begin
        if (close_cell) begin
            cell_len[close_idx] <= close_len;
            cell_eop[close_idx] <= close_eop;
        end
    end

    // complete-cell and whole-packet counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_full <= '0;
            pkts_held  <= '0;
        end else begin
            count_full <= count_full + CNT_W'(close_cell) - CNT_W'(pop_cell);
            pkts_held  <= pkts_held + CNT_W'(close_cell && close_eop) - CNT_W'(pop_eop);
        end
    end

    // byte select and output register
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (byte_fire)
            rd_data <= mem[rd_addr][8*rd_lane +: 8];
    end

    // R1: complete cells never exceed capacity
    p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        count_full <= CNT_W'(NUM_CELLS));

    // R1: a full store refuses the next word
    p_full_refuses_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (count_full == CNT_W'(NUM_CELLS)) |-> !wr_fire);

    // R3: every held packet owns at least one complete cell
    p_pkts_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pkts_held <= count_full);

    // R2: sending only begins from a start condition
    p_start_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_active) |-> $past(start_ok));

endmodule

// File: tb/txcell_fifo_bench.sv
module txcell_fifo_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  cfg_thresh;
    logic        wr_valid;
    logic        wr_ready;
    logic [63:0] wr_data;
    logic        wr_eop;
    logic [2:0]  wr_last_bytes;
    logic        rd_en;
    logic        tx_active;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic        rd_last;
    logic        underrun;

    int nchk  = 0;
    int nfail = 0;

    always #10 clk = ~clk;

    txcell_fifo u_txcell_fifo (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_thresh    (cfg_thresh),
        .wr_valid      (wr_valid),
        .wr_ready      (wr_ready),
        .wr_data       (wr_data),
        .wr_eop        (wr_eop),
        .wr_last_bytes (wr_last_bytes),
        .rd_en         (rd_en),
        .tx_active     (tx_active),
        .rd_valid      (rd_valid),
        .rd_data       (rd_data),
        .rd_last       (rd_last),
        .underrun      (underrun)
    );

    // vector: {threshold[15:11], packet length in bytes[10:0]}
    localparam int NVEC = 9;
    localparam logic [15:0] VEC [NVEC] = '{
        {5'd4,  11'd100},
        {5'd1,  11'd64},
        {5'd0,  11'd200},
        {5'd30, 11'd1536},
        {5'd24, 11'd1536},
        {5'd2,  11'd129},
        {5'd3,  11'd8},
        {5'd5,  11'd1},
        {5'd24, 11'd65}
    };

    function automatic logic [7:0] pat(int seed, int i);
        return 8'((seed * 37 + i * 13 + (i >> 8)) & 255);
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive_word(int seed, int len, int w);
        int nw = (len + 7) / 8;
        for (int b = 0; b < 8; b++) begin
            int idx = w * 8 + b;
            wr_data[8*b +: 8] = (idx < len) ? pat(seed, idx) : 8'h00;
        end
        wr_eop        = (w == nw - 1);
        wr_last_bytes = 3'(len % 8);
        wr_valid      = 1'b1;
    endtask

    // writes a packet, holding junk end-of-packet words while wr_ready is low
    task automatic write_pkt(int seed, int len, int first_w);
        int nw = (len + 7) / 8;
        for (int w = first_w; w < nw; w++) begin
            while (!wr_ready) begin
                wr_valid      = 1'b1;
                wr_data       = '1;
                wr_eop        = 1'b1;
                wr_last_bytes = 3'd1;
                @(negedge clk);
            end
            drive_word(seed, len, w);
            @(negedge clk);
        end
        wr_valid = 1'b0;
        wr_eop   = 1'b0;
    endtask

    task automatic wait_active();
        for (int c = 0; c < 400 && !tx_active; c++) @(negedge clk);
    endtask

    task automatic read_pkt(int seed, int len, string req);
        int got = 0;
        int bad = 0;
        int badlast = 0;
        int urun = 0;
        rd_en = 1'b1;
        for (int c = 0; c < 5000; c++) begin
            @(negedge clk);
            if (underrun) urun++;
            if (rd_valid) begin
                if (rd_data !== pat(seed, got)) bad++;
                if (rd_last !== (got == len - 1)) badlast++;
                got++;
                if (rd_last) break;
            end
        end
        rd_en = 1'b0;
        check(got == len, req, "byte count", got, len);
        check(bad == 0, req, "data mismatches", bad, 0);
        check(badlast == 0, req, "rd_last misplaced", badlast, 0);
        check(urun == 0, "R7", "underrun pulses", urun, 0);
        check(tx_active == 1'b0, req, "tx_active after last", tx_active, 0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog timeout actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        int first;
        int vc, vu;
        rst_n = 1'b0; cfg_thresh = 5'd4; wr_valid = 1'b0; wr_data = '0;
        wr_eop = 1'b0; wr_last_bytes = '0; rd_en = 1'b0;
        do_reset();

        // R10: reset state
        check(wr_ready == 1'b1, "R10", "wr_ready", wr_ready, 1);
        check(tx_active == 1'b0, "R10", "tx_active", tx_active, 0);
        check(rd_valid == 1'b0 && rd_last == 1'b0, "R10", "rd_valid/rd_last", rd_valid, 0);
        check(underrun == 1'b0, "R10", "underrun", underrun, 0);

        // R11: requests while idle produce nothing
        vc = 0; vu = 0;
        rd_en = 1'b1;
        repeat (6) begin
            @(negedge clk);
            if (rd_valid) vc++;
            if (underrun) vu++;
        end
        rd_en = 1'b0;
        check(vc == 0, "R11", "rd_valid while idle", vc, 0);
        check(vu == 0, "R11", "underrun while idle", vu, 0);

        // vector walk: start timing (R2, R3, R4) then stream check (R5, R6)
        for (int v = 0; v < NVEC; v++) begin
            int thr  = int'(VEC[v][15:11]);
            int len  = int'(VEC[v][10:0]);
            int teff = (thr == 0) ? 1 : (thr > 24 ? 24 : thr);
            int nw   = (len + 7) / 8;
            int sw   = (teff * 8 < nw) ? teff * 8 : nw;
            cfg_thresh = 5'(thr);
            first = 0;
            for (int w = 0; w < nw + 3; w++) begin
                if (w < nw) drive_word(100 + v, len, w);
                else wr_valid = 1'b0;
                @(negedge clk);
                if (tx_active && first == 0) first = w + 1;
            end
            wr_valid = 1'b0;
            check(first == sw + 1, (sw < nw) ? "R2" : "R3", "start cycle", first, sw + 1);
            read_pkt(100 + v, len, (len % 8 != 0 || len % 64 != 0) ? "R5" : "R6");
        end

        // R7: packet within threshold, written while it is being read
        cfg_thresh = 5'd5;
        fork
            write_pkt(70, 300, 0);
            begin
                wait_active();
                read_pkt(70, 300, "R7");
            end
        join

        // R1: full store holds off junk words until a cell drains
        cfg_thresh = 5'd24;
        fork
            write_pkt(80, 1544, 0);
            begin
                wait_active();
                check(wr_ready == 1'b0, "R1", "wr_ready when full", wr_ready, 0);
                repeat (3) @(negedge clk);
                check(wr_ready == 1'b0, "R1", "wr_ready still low", wr_ready, 0);
                read_pkt(80, 1544, "R1");
            end
        join

        // R3: two whole packets queued back to back
        cfg_thresh = 5'd24;
        write_pkt(90, 20, 0);
        write_pkt(91, 70, 0);
        read_pkt(90, 20, "R3");
        read_pkt(91, 70, "R3");

        // R8, R9: slow writer forces underrun, then discard and recovery
        cfg_thresh = 5'd1;
        for (int w = 0; w < 8; w++) begin
            drive_word(50, 200, w);
            @(negedge clk);
        end
        wr_valid = 1'b0;
        wait_active();
        vc = 0; vu = 0;
        rd_en = 1'b1;
        for (int c = 0; c < 80; c++) begin
            @(negedge clk);
            if (rd_valid) begin
                if (rd_data !== pat(50, vc))
                    check(0, "R8", "pre-underrun data", rd_data, pat(50, vc));
                vc++;
            end
            if (underrun) vu++;
        end
        rd_en = 1'b0;
        check(vc == 64, "R8", "bytes before underrun", vc, 64);
        check(vu == 1, "R8", "underrun pulses", vu, 1);
        check(tx_active == 1'b0, "R8", "tx_active after underrun", tx_active, 0);
        write_pkt(50, 200, 8);
        write_pkt(60, 10, 0);
        read_pkt(60, 10, "R9");

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule